// File: doc/BRIEF.md
# Wakeup RTC Counter Peripheral

This block is a memory-mapped real-time counter for suspend and wakeup use. It has a free-running binary counter, a clock source picked from four input strobes, and an optional prescaler built from a divide-by-32 stage and a divide-by-512 stage that can be chained. Software reaches it over a simple 32-bit register bus with a write strobe, a read strobe and a byte address. Read data is registered.

Three events set sticky status flags: an alarm compare match, a periodic compare match and a counter wrap to zero. Software clears a flag by writing a one to its bit. A single registered interrupt line combines the flags with their enables, and the alarm enable gates the rollover flag as well. The four clock inputs arrive as single-cycle enable strobes in the system clock domain. Clock and prescaler settings can only be changed while the counter is stopped. A change to them restarts the count from zero. After each accepted write to the alarm register there is a short synchronization window, and status shows it as busy.

Top module: `wkrtc_top`

## Requirements
- R1: After the synchronous reset every register reads zero (control 0x04, status 0x08, count 0x0C, periodic 0x10, alarm 0x14) and `irq` is low. A read returns data on `bus_rdata` in the cycle after `bus_rd`.
- R2: The counter advances by exactly one per prescaled tick, and only while control bit 31 is set. It holds its value while that bit is clear. Writes to the count register at 0x0C have no effect.
- R3: Control bits 13:12 select which bit of `src_en` drives the counter. Strobes on the other three bits do not advance it.
- R4: Control bit 10 divides the selected strobe by 32 and bit 11 divides it by 512. With both bits set the stages chain to divide by 16384. With neither bit set every strobe is a tick.
- R5: While control bit 15 is set, status bit 13 sets on the tick that moves the counter onto the periodic value (0x10). Status bit 29 sets on the tick that moves the counter onto the alarm value (0x14).
- R6: While control bit 31 is 1, writes to control bits 13:10 are ignored. A write that changes those bits while the counter is stopped clears the counter and the prescaler.
- R7: The counter wraps from all ones to zero. Status bit 10 sets on that wrap only when control bit 28 is set.
- R8: Writing a one to status bit 29, 13 or 10 clears that flag. Flags stay set until cleared. If an event lands in the same cycle as a clear of its flag, the flag stays set.
- R9: An accepted alarm write sets status bit 18 for 3 ticks. Alarm writes made while bit 18 is set are ignored.
- R10: Alarm values below 4, zero included, never set status bit 29.
- R11: `irq` is registered and equals (alarm flag OR rollover flag) AND control bit 30, OR (periodic flag AND control bit 14). It rises one cycle after the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_en | input | 4 | One-cycle strobes of the four candidate count clocks |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The collision that matters is a write-one-to-clear on the status register landing in the same cycle as a compare event on the same flag. The bench sets the periodic value to the next count. It then drives one selected-source strobe and a status write clearing bit 13 on the same clock edge, and expects bit 13 to read back set. A later clear with no event present must bring the flag to zero. The bench also times alarm writes inside the synchronization window so that they meet a running busy count, and expects those writes to leave the stored value unchanged.

// File: rtl/wkrtc_pkg.sv
package wkrtc_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_STAT = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_CNT  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_PER  = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_ALM  = 5'h14;

  // control field positions (software decodes these)
  localparam int B_RUN    = 31;
  localparam int B_ALM_IE = 30;
  localparam int B_ROV_EN = 28;
  localparam int B_PER_EN = 15;
  localparam int B_PER_IE = 14;
  localparam int B_SEL_LO = 12;
  localparam int B_D512   = 11;
  localparam int B_D32    = 10;

  // status field positions
  localparam int S_ALM  = 29;
  localparam int S_BUSY = 18;
  localparam int S_PER  = 13;
  localparam int S_ROV  = 10;

  typedef struct packed {
    logic       run;
    logic       alm_ie;
    logic       rov_en;
    logic       per_en;
    logic       per_ie;
    logic [1:0] sel;
    logic       d512;
    logic       d32;
  } ctrl_t;
endpackage

// File: rtl/wkrtc_prescale.sv
module wkrtc_prescale #(
  parameter int SEL_W      = 2,
  parameter int PRE_A_LOG2 = 9,
  parameter int PRE_B_LOG2 = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [(1<<SEL_W)-1:0] src_en,
  input  logic [SEL_W-1:0]      sel,
  input  logic                  run,
  input  logic                  use_a,
  input  logic                  use_b,
  input  logic                  restart,
  output logic                  tick
);
  logic [PRE_A_LOG2-1:0] cnt_a;
  logic [PRE_B_LOG2-1:0] cnt_b;
  logic src_hit, a_out;

  assign src_hit = run & src_en[sel];
  // first stage (divide by 2^PRE_A_LOG2) feeds the second stage
  assign a_out   = src_hit & (~use_a | (&cnt_a));
  assign tick    = a_out & (~use_b | (&cnt_b));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_a <= '0;
      cnt_b <= '0;
    end else begin
      if (src_hit && use_a) cnt_a <= cnt_a + 1'b1;
      if (a_out && use_b)   cnt_b <= cnt_b + 1'b1;
    end
  end
endmodule

// File: rtl/wkrtc_events.sv
module wkrtc_events #(
  parameter int CNT_W      = 32,
  parameter int SYNC_TICKS = 3,
  parameter int ALM_MIN    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             restart,
  input  logic             rov_en,
  input  logic             per_en,
  input  logic [CNT_W-1:0] per_val,
  input  logic [CNT_W-1:0] alm_val,
  input  logic             alm_load,
  output logic [CNT_W-1:0] cnt,
  output logic             ev_alm,
  output logic             ev_per,
  output logic             ev_rov,
  output logic             sync_busy
);
  localparam int SYNC_W = $clog2(SYNC_TICKS + 1);

  logic [CNT_W-1:0]  cnt_nxt;
  logic [SYNC_W-1:0] sync_cnt;

  assign cnt_nxt   = cnt + CNT_W'(1);
  assign ev_rov    = tick & rov_en & (&cnt);
  assign ev_per    = tick & per_en & (cnt_nxt == per_val);
  assign ev_alm    = tick & (alm_val >= CNT_W'(ALM_MIN)) & (cnt_nxt == alm_val);
  assign sync_busy = (sync_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (tick)      cnt <= cnt_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst)                           sync_cnt <= '0;
    else if (alm_load)                 sync_cnt <= SYNC_W'(SYNC_TICKS);
    else if (tick && sync_cnt != '0)   sync_cnt <= sync_cnt - 1'b1;
  end

  // R2: counter holds without a tick
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !restart) |=> $stable(cnt));
  // R2: one step per tick, wrapping at all ones
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (tick && !restart) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
endmodule

// File: rtl/wkrtc_top.sv
module wkrtc_top #(
  parameter int CNT_W      = 32,
  parameter int PRE_A_LOG2 = 9,
  parameter int PRE_B_LOG2 = 5,
  parameter int SYNC_TICKS = 3,
  parameter int ALM_MIN    = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [3:0]  src_en,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  import wkrtc_pkg::*;

  ctrl_t            ctrl;
  logic             st_alm, st_per, st_rov;
  logic [CNT_W-1:0] per_val, alm_val, cnt;
  logic             tick, restart, sync_busy, alm_load;
  logic             ev_alm, ev_per, ev_rov;
  logic             wr_ctrl, wr_stat, wr_per, wr_alm;
  logic [3:0]       new_cfg;
  logic [BUS_W-1:0] ctrl_word, stat_word;

  assign wr_ctrl  = bus_wr && (bus_addr == OFF_CTRL);
  assign wr_stat  = bus_wr && (bus_addr == OFF_STAT);
  assign wr_per   = bus_wr && (bus_addr == OFF_PER);
  assign wr_alm   = bus_wr && (bus_addr == OFF_ALM);
  assign alm_load = wr_alm && !sync_busy;
  assign new_cfg  = {bus_wdata[B_SEL_LO +: 2], bus_wdata[B_D512], bus_wdata[B_D32]};
  assign restart  = wr_ctrl && !ctrl.run && (new_cfg != {ctrl.sel, ctrl.d512, ctrl.d32});

  wkrtc_prescale #(.SEL_W(2), .PRE_A_LOG2(PRE_A_LOG2), .PRE_B_LOG2(PRE_B_LOG2)) u_pre (
    .clk(clk), .rst(rst), .src_en(src_en), .sel(ctrl.sel), .run(ctrl.run),
    .use_a(ctrl.d512), .use_b(ctrl.d32), .restart(restart), .tick(tick)
  );

  wkrtc_events #(.CNT_W(CNT_W), .SYNC_TICKS(SYNC_TICKS), .ALM_MIN(ALM_MIN)) u_ev (
    .clk(clk), .rst(rst), .tick(tick), .restart(restart), .rov_en(ctrl.rov_en),
    .per_en(ctrl.per_en), .per_val(per_val), .alm_val(alm_val), .alm_load(alm_load),
    .cnt(cnt), .ev_alm(ev_alm), .ev_per(ev_per), .ev_rov(ev_rov), .sync_busy(sync_busy)
  );

  // control register: clock fields frozen while counting
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (wr_ctrl) begin
      ctrl.run    <= bus_wdata[B_RUN];
      ctrl.alm_ie <= bus_wdata[B_ALM_IE];
      ctrl.rov_en <= bus_wdata[B_ROV_EN];
      ctrl.per_en <= bus_wdata[B_PER_EN];
      ctrl.per_ie <= bus_wdata[B_PER_IE];
      if (!ctrl.run) {ctrl.sel, ctrl.d512, ctrl.d32} <= new_cfg;
    end
  end

  // compare registers
  always_ff @(posedge clk) begin
    if (rst) begin
      per_val <= '0;
      alm_val <= '0;
    end else begin
      if (wr_per)   per_val <= bus_wdata[CNT_W-1:0];
      if (alm_load) alm_val <= bus_wdata[CNT_W-1:0];
    end
  end

  // sticky flags, set beats clear
  always_ff @(posedge clk) begin
    if (rst) begin
      st_alm <= 1'b0;
      st_per <= 1'b0;
      st_rov <= 1'b0;
    end else begin
      st_alm <= ev_alm | (st_alm & ~(wr_stat & bus_wdata[S_ALM]));
      st_per <= ev_per | (st_per & ~(wr_stat & bus_wdata[S_PER]));
      st_rov <= ev_rov | (st_rov & ~(wr_stat & bus_wdata[S_ROV]));
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[B_RUN]         = ctrl.run;
    ctrl_word[B_ALM_IE]      = ctrl.alm_ie;
    ctrl_word[B_ROV_EN]      = ctrl.rov_en;
    ctrl_word[B_PER_EN]      = ctrl.per_en;
    ctrl_word[B_PER_IE]      = ctrl.per_ie;
    ctrl_word[B_SEL_LO +: 2] = ctrl.sel;
    ctrl_word[B_D512]        = ctrl.d512;
    ctrl_word[B_D32]         = ctrl.d32;
    stat_word = '0;
    stat_word[S_ALM]  = st_alm;
    stat_word[S_BUSY] = sync_busy;
    stat_word[S_PER]  = st_per;
    stat_word[S_ROV]  = st_rov;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= ((st_alm | st_rov) & ctrl.alm_ie) | (st_per & ctrl.per_ie);
      if (bus_rd) begin
        case (bus_addr)
          OFF_CTRL: bus_rdata <= ctrl_word;
          OFF_STAT: bus_rdata <= stat_word;
          OFF_CNT:  bus_rdata <= BUS_W'(cnt);
          OFF_PER:  bus_rdata <= BUS_W'(per_val);
          OFF_ALM:  bus_rdata <= BUS_W'(alm_val);
          default:  bus_rdata <= '0;
        endcase
      end
    end
  end

  // R6: clock configuration cannot move while counting
  a_r6_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    ctrl.run |=> $stable({ctrl.sel, ctrl.d512, ctrl.d32}));
  // R7: wrap with rollover detection enabled leaves the flag set
  a_r7_rov_flag: assert property (@(posedge clk) disable iff (rst)
    (tick && (&cnt) && ctrl.rov_en) |=> st_rov);
  // R9: alarm writes inside the sync window are dropped
  a_r9_busy_blocks: assert property (@(posedge clk) disable iff (rst)
    (wr_alm && sync_busy) |=> $stable(alm_val));
  // R11: with both enables effectively off, no request follows
  a_r11_irq_masked: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.alm_ie && !(st_per && ctrl.per_ie)) |=> !irq);
endmodule

// File: tb/wkrtc_top_tb_top.sv
module wkrtc_top_tb_top;
  localparam logic [4:0] A_CTRL = 5'h04, A_STAT = 5'h08, A_CNT = 5'h0C,
                         A_PER = 5'h10, A_ALM = 5'h14;
  localparam logic [31:0] RUN = 32'h8000_0000, AIE = 32'h4000_0000, ROV = 32'h1000_0000,
                          PEN = 32'h0000_8000, PIE = 32'h0000_4000, SEL2 = 32'h0000_2000,
                          SEL1 = 32'h0000_1000, D512 = 32'h0000_0800, D32 = 32'h0000_0400;
  localparam logic [31:0] F_ALM = 32'h2000_0000, F_BUSY = 32'h0004_0000,
                          F_PER = 32'h0000_2000, F_ROV = 32'h0000_0400;
  localparam logic [3:0] S2 = 4'b0100, S0 = 4'b0001;

  logic        clk = 1'b0, rst = 1'b1;
  logic [3:0]  src_en = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic rd_seen = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  wkrtc_top #(.CNT_W(10)) dut_i (
    .clk(clk), .rst(rst), .src_en(src_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always @(posedge clk) rd_seen <= bus_rd;

  // monitor: pop one expected read per returned word
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (bus_rdata !== e) begin
        n_bad++;
        $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [4:0] a, input logic [31:0] e, input string t);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] m, input int n);
    repeat (n) begin @(negedge clk); src_en = m; end
    @(negedge clk); src_en = '0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    n_cmp++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s: irq got %b expected %b", t, irq, e);
    end
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd_exp(A_CTRL, 0, "R1 ctrl");
    rd_exp(A_STAT, 0, "R1 status");
    rd_exp(A_CNT, 0, "R1 count");
    rd_exp(A_ALM, 0, "R1 alarm");
    chk_irq(1'b0, "R1 irq");

    // R2/R3 counting from source 2
    wr(A_CTRL, SEL2);
    wr(A_CTRL, RUN | SEL2);
    pulse(S2, 5);
    rd_exp(A_CNT, 5, "R2 count five ticks");
    pulse(S0, 3);
    rd_exp(A_CNT, 5, "R3 other source ignored");
    rd_exp(A_CTRL, RUN | SEL2, "R3 ctrl readback");

    // R6 frozen config while running
    wr(A_CTRL, RUN | SEL1 | D32);
    rd_exp(A_CTRL, RUN | SEL2, "R6 cfg ignored while running");
    rd_exp(A_CNT, 5, "R6 no restart while running");
    pulse(S2, 1);
    rd_exp(A_CNT, 6, "R6 still undivided");

    // R2 stop holds, R6 restart on change
    wr(A_CTRL, SEL2);
    pulse(S2, 2);
    rd_exp(A_CNT, 6, "R2 held while stopped");
    wr(A_CTRL, SEL2 | D32);
    rd_exp(A_CNT, 0, "R6 restart on cfg change");

    // R4 prescaler ratios
    wr(A_CTRL, RUN | SEL2 | D32);
    pulse(S2, 31);
    rd_exp(A_CNT, 0, "R4 div32 before tick");
    pulse(S2, 1);
    rd_exp(A_CNT, 1, "R4 div32 tick");
    wr(A_CTRL, SEL2 | D32);
    rd_exp(A_CNT, 1, "R6 same cfg keeps count");
    wr(A_CTRL, SEL2 | D512);
    wr(A_CTRL, RUN | SEL2 | D512);
    pulse(S2, 511);
    rd_exp(A_CNT, 0, "R4 div512 before tick");
    pulse(S2, 1);
    rd_exp(A_CNT, 1, "R4 div512 tick");
    wr(A_CTRL, SEL2 | D512);
    wr(A_CTRL, SEL2 | D512 | D32);
    wr(A_CTRL, RUN | SEL2 | D512 | D32);
    pulse(S2, 16383);
    rd_exp(A_CNT, 0, "R4 div16384 before tick");
    pulse(S2, 1);
    rd_exp(A_CNT, 1, "R4 div16384 tick");
    wr(A_CTRL, SEL2 | D512 | D32);
    wr(A_CTRL, SEL2);

    // R5 periodic compare, R11 irq, R8 clear
    wr(A_PER, 10);
    wr(A_CTRL, RUN | PEN | PIE | SEL2);
    pulse(S2, 9);
    rd_exp(A_STAT, 0, "R5 no periodic before match");
    chk_irq(1'b0, "R11 irq idle");
    pulse(S2, 1);
    rd_exp(A_STAT, F_PER, "R5 periodic match");
    chk_irq(1'b1, "R11 periodic irq");
    pulse(S2, 1);
    rd_exp(A_STAT, F_PER, "R8 flag sticky");
    rd_exp(A_CNT, 11, "R5 counter keeps running");
    wr(A_STAT, F_PER);
    rd_exp(A_STAT, 0, "R8 w1c periodic");
    chk_irq(1'b0, "R11 irq after clear");

    // R9 sync window, R5 alarm
    wr(A_CTRL, RUN | AIE | SEL2);
    wr(A_ALM, 16);
    rd_exp(A_STAT, F_BUSY, "R9 busy after alarm write");
    wr(A_ALM, 50);
    rd_exp(A_ALM, 16, "R9 write during busy ignored");
    pulse(S2, 3);
    rd_exp(A_STAT, 0, "R9 busy clears after three ticks");
    pulse(S2, 2);
    rd_exp(A_STAT, F_ALM, "R5 alarm match");
    chk_irq(1'b1, "R11 alarm irq");
    wr(A_STAT, F_ALM);
    rd_exp(A_STAT, 0, "R8 w1c alarm");

    // R10 small alarm values
    wr(A_CTRL, AIE | SEL2);
    wr(A_CTRL, AIE | SEL2 | D32);
    wr(A_CTRL, AIE | SEL2);
    wr(A_CTRL, RUN | AIE | SEL2);
    wr(A_ALM, 2);
    pulse(S2, 5);
    rd_exp(A_STAT, 0, "R10 alarm value 2 never matches");
    wr(A_ALM, 0);
    pulse(S2, 3);
    rd_exp(A_CNT, 8, "R2 count after restart");

    // R7 rollover, R10 alarm 0 at wrap, R11 mask
    wr(A_CTRL, RUN | AIE | ROV | SEL2);
    pulse(S2, 1015);
    rd_exp(A_STAT, 0, "R7 before wrap");
    pulse(S2, 1);
    rd_exp(A_CNT, 0, "R7 wrapped to zero");
    rd_exp(A_STAT, F_ROV, "R7 rollover flag, R10 zero alarm silent");
    chk_irq(1'b1, "R11 rollover irq via alarm enable");
    wr(A_CTRL, RUN | ROV | SEL2);
    rd_exp(A_STAT, F_ROV, "R8 flag kept when enable removed");
    chk_irq(1'b0, "R11 alarm enable masks rollover");
    wr(A_STAT, F_ROV);
    wr(A_CTRL, RUN | AIE | SEL2);
    pulse(S2, 1024);
    rd_exp(A_CNT, 0, "R7 second wrap");
    rd_exp(A_STAT, 0, "R7 no flag without detect enable");
    chk_irq(1'b0, "R11 no irq");

    // R8 set beats clear in the same cycle
    wr(A_PER, 3);
    wr(A_CTRL, RUN | PEN | PIE | SEL2);
    pulse(S2, 3);
    rd_exp(A_STAT, F_PER, "R5 periodic at 3");
    wr(A_PER, 4);
    @(negedge clk); src_en = S2; bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = F_PER;
    @(negedge clk); src_en = '0; bus_wr = 1'b0;
    rd_exp(A_STAT, F_PER, "R8 event wins over clear");
    wr(A_STAT, F_PER);
    rd_exp(A_STAT, 0, "R8 clear without event");

    // R2 count register read-only
    wr(A_CNT, 123);
    rd_exp(A_CNT, 4, "R2 count write ignored");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule